// File: doc/BRIEF.md
# Multi-Mode Supervisory Watchdog

This block is the watchdog of a supervisory controller. It picks one of three behaviours from the controller's operating mode, a mode-select control bit and an external disable pin. In Window mode, software must refresh the counter in the second half of a programmable period. A refresh that comes too soon requests a reset, and so does a period that passes with no refresh. In Timeout mode, a refresh is allowed at any time. A first overflow only raises a pending interrupt. A second overflow while that interrupt is still unacknowledged escalates to a reset request. In Off mode the counter is held at zero.

Every reset request is a one-cycle pulse that carries a cause code. The request clears the counter and the pending interrupt. Changing the disable pin always forces a reset. Changing the mode-select bit forces a reset while the controller is in Normal mode. The reset request goes to downstream logic, which shapes the actual reset line.

Top module: `wdg_supervisor`

## Requirements
- R1: The watchdog mode is decoded from the operating mode code (0 Normal, 1 Standby, 2 Sleep, 3 Overtemp, 4 Off, 5 to 7 treated as Off) as follows. With the disable pin low, Normal with the select bit clear gives Window. Normal with the bit set, or Standby with the bit clear, gives Timeout. Every other combination, and any case with the disable pin high, gives Off. `wd_mode_o` reports 0 Off, 1 Window, 2 Timeout, one clock after the inputs are presented.
- R2: In Off mode the counter is held at zero and refresh strobes are ignored. No interrupt is raised and no reset is requested, however long the block stays there, apart from the pin or select-bit change resets of R9 and R10.
- R3: The period P is `period_i`, with values below 2 treated as 2. On entry to Timeout mode the counter restarts. The first overflow, on the P+1th clock after entry, sets `irq_pend_o` if no interrupt is pending. The counter then wraps and keeps running.
- R4: A Timeout-mode overflow while the interrupt is still pending requests a reset with cause 3 and clears the pending flag.
- R5: In Timeout mode a refresh restarts the counter at any count, including the first half of the period, and never causes a reset.
- R6: An acknowledge strobe clears `irq_pend_o` on the next clock. The next overflow after an acknowledge raises the interrupt again rather than a reset.
- R7: In Window mode, a period that passes with no refresh requests a reset with cause 1 on the P+1th clock after the counter restarts.
- R8: In Window mode, a refresh while the count is below P/2 (integer halving) requests a reset with cause 2. A refresh at a count of P/2 or more restarts the counter with no reset.
- R9: A change of the select bit while the operating mode is Normal requests a reset with cause 4. A change in any other operating mode requests none.
- R10: Any change of the disable pin level requests a reset with cause 5, in every operating mode.
- R11: `rst_req_o` is a one-clock pulse and `rst_cause_o` is 0 whenever it is low. If several causes coincide, the priority is 5, 4, 2, 1, 3. The request restarts the counter and clears the pending interrupt.
- R12: After reset, `irq_pend_o` and `rst_req_o` are 0, `rst_cause_o` is 0 and `wd_mode_o` is Off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kick_i | input | 1 | Watchdog refresh strobe, one clock wide |
| sys_mode_i | input | 3 | Operating mode code of the controller |
| sel_i | input | 1 | Mode-select control bit |
| dis_pin_i | input | 1 | External watchdog disable pin, high disables |
| irq_ack_i | input | 1 | Acknowledge strobe for the pending interrupt |
| period_i | input | PERIOD_W | Watchdog period in clocks |
| irq_pend_o | output | 1 | Pending watchdog interrupt |
| rst_req_o | output | 1 | Reset request pulse |
| rst_cause_o | output | 3 | Reset cause, valid with the request |
| wd_mode_o | output | 2 | Current watchdog mode |

## Verification
Every result is registered, so a mode or level change seen at one clock edge shows up after that edge. A select or pin change produces its request one clock after it is presented, and an acknowledge clears the flag one clock later. An early refresh is punished on the clock that samples it. The first overflow falls P+1 clocks after mode entry, and the escalation comes P clocks after that. The bench drives inputs and samples outputs on the falling edge. It checks each result both one clock before it is due, to confirm it is absent, and on the exact clock it is due, so a one-cycle slip in either direction is reported.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [2:0] {
    SYS_NORMAL   = 3'd0,
    SYS_STANDBY  = 3'd1,
    SYS_SLEEP    = 3'd2,
    SYS_OVERTEMP = 3'd3,
    SYS_OFF      = 3'd4
  } sys_mode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_WINDOW  = 2'd1,
    WD_TIMEOUT = 2'd2
  } wd_mode_e;

  typedef enum logic [2:0] {
    RC_NONE       = 3'd0,
    RC_WIN_LATE   = 3'd1,
    RC_WIN_EARLY  = 3'd2,
    RC_ESCALATE   = 3'd3,
    RC_SEL_CHANGE = 3'd4,
    RC_PIN_CHANGE = 3'd5
  } rst_cause_e;

endpackage

// File: rtl/wdg_mode_decode.sv
module wdg_mode_decode
  import wdg_pkg::*;
(
  input  logic [2:0] sys_mode_i,
  input  logic       sel_i,
  input  logic       dis_i,
  output wd_mode_e   mode_o
);

  always_comb begin
    mode_o = WD_OFF;
    if (!dis_i) begin
      if (sys_mode_i == SYS_NORMAL) begin
        mode_o = sel_i ? WD_TIMEOUT : WD_WINDOW;
      end else if ((sys_mode_i == SYS_STANDBY) && !sel_i) begin
        mode_o = WD_TIMEOUT;
      end
    end
  end

  // R1: a high disable pin always yields Off
  always_comb begin
    if (dis_i) assert_pin_forces_off_R1: assert (mode_o == WD_OFF);
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [CW-1:0] period_i,
  output logic          ovf_o,
  output logic          early_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] MIN_LIM = CW'(2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim, last, half;
  logic          cnt_en;

  always_comb begin
    lim  = (period_i < MIN_LIM) ? MIN_LIM : period_i;
    last = lim - CW'(1);
    half = lim >> 1;
  end

  assign ovf_o   = run_i && (cnt_q >= last);
  assign early_o = (cnt_q < half);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || restart_i) begin
      cnt_d = '0;
    end else if (cnt_q >= last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a stopped counter sits at zero
  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  // R3: a running counter never passes the last count
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $stable(period_i)) |=> (cnt_q <= last));

endmodule

// File: rtl/wdg_event_ctrl.sv
module wdg_event_ctrl
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wd_mode_e   mode_c_i,
  input  logic [2:0] sys_mode_i,
  input  logic       sel_i,
  input  logic       dis_i,
  input  logic       kick_i,
  input  logic       ack_i,
  input  logic       ovf_i,
  input  logic       early_i,
  output logic       restart_o,
  output logic       irq_o,
  output logic       req_o,
  output rst_cause_e cause_o,
  output wd_mode_e   mode_o
);

  logic       seen_q, pin_q, sel_q;
  logic       irq_q, irq_d, irq_en;
  logic       req_q, req_d;
  rst_cause_e cause_q, cause_d;
  wd_mode_e   mode_q;

  logic pin_chg, sel_chg, mode_chg;
  logic win_early, win_late, to_ovf, escalate, pend_eff;

  always_comb begin
    pin_chg   = seen_q && (dis_i != pin_q);
    sel_chg   = seen_q && (sys_mode_i == SYS_NORMAL) && (sel_i != sel_q);
    mode_chg  = (mode_c_i != mode_q);
    win_early = (mode_c_i == WD_WINDOW) && !mode_chg && kick_i && early_i;
    win_late  = (mode_c_i == WD_WINDOW) && !mode_chg && !kick_i && ovf_i;
    to_ovf    = (mode_c_i == WD_TIMEOUT) && !mode_chg && !kick_i && ovf_i;
    pend_eff  = irq_q && !ack_i;
    escalate  = to_ovf && pend_eff;
  end

  always_comb begin
    if (pin_chg)        cause_d = RC_PIN_CHANGE;
    else if (sel_chg)   cause_d = RC_SEL_CHANGE;
    else if (win_early) cause_d = RC_WIN_EARLY;
    else if (win_late)  cause_d = RC_WIN_LATE;
    else if (escalate)  cause_d = RC_ESCALATE;
    else                cause_d = RC_NONE;
    req_d = (cause_d != RC_NONE);
  end

  always_comb begin
    irq_en = req_d || to_ovf || ack_i;
    if (req_d)        irq_d = 1'b0;
    else if (to_ovf)  irq_d = 1'b1;
    else              irq_d = 1'b0;
  end

  assign restart_o = req_d || mode_chg || (kick_i && (mode_c_i != WD_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pin_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      pin_q  <= dis_i;
      sel_q  <= sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= RC_NONE;
      mode_q  <= WD_OFF;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
      if (mode_chg) mode_q <= mode_c_i;
    end
  end

  assign irq_o   = irq_q;
  assign req_o   = req_q;
  assign cause_o = cause_q;
  assign mode_o  = mode_q;

  // R10: a pin level change always ends in a pin-change request
  assert_pin_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (dis_i != pin_q)) |=> (req_q && (cause_q == RC_PIN_CHANGE)));

  // R4: escalation only comes from an already pending interrupt
  assert_escalate_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && (cause_q == RC_ESCALATE)) |-> $past(irq_q));

  // R3: the interrupt only rises from Timeout mode
  assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(mode_c_i == WD_TIMEOUT));

  // R8: an early-refresh cause needs a refresh strobe
  assert_early_needs_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && (cause_q == RC_WIN_EARLY)) |-> $past(kick_i));

  // R2: Off mode stays quiet apart from pin and select changes
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_c_i == WD_OFF) && !pin_chg && !sel_chg) |=> (!req_q && !$rose(irq_q)));

  // R11: the cause is idle whenever no request is shown
  assert_cause_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (cause_q == RC_NONE));

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick_i,
  input  logic [2:0]          sys_mode_i,
  input  logic                sel_i,
  input  logic                dis_pin_i,
  input  logic                irq_ack_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                irq_pend_o,
  output logic                rst_req_o,
  output logic [2:0]          rst_cause_o,
  output logic [1:0]          wd_mode_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  wd_mode_e            mode_c, mode_q;
  rst_cause_e          cause;
  logic                ovf, early, restart;
  logic [PERIOD_W-1:0] cnt;

  wdg_mode_decode u_decode (
    .sys_mode_i (sys_mode_i),
    .sel_i      (sel_i),
    .dis_i      (dis_pin_i),
    .mode_o     (mode_c)
  );

  wdg_counter #(.CW(PERIOD_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (mode_c != WD_OFF),
    .restart_i (restart),
    .period_i  (period_i),
    .ovf_o     (ovf),
    .early_o   (early),
    .cnt_o     (cnt)
  );

  wdg_event_ctrl u_events (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_c_i   (mode_c),
    .sys_mode_i (sys_mode_i),
    .sel_i      (sel_i),
    .dis_i      (dis_pin_i),
    .kick_i     (kick_i),
    .ack_i      (irq_ack_i),
    .ovf_i      (ovf),
    .early_i    (early),
    .restart_o  (restart),
    .irq_o      (irq_pend_o),
    .req_o      (rst_req_o),
    .cause_o    (cause),
    .mode_o     (mode_q)
  );

  assign rst_cause_o = cause;
  assign wd_mode_o   = mode_q;

  // R11: a request leaves the counter restarted and the interrupt cleared
  assert_req_clears_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req_o |-> ((cnt == '0) && !irq_pend_o));

endmodule

// File: tb/sim_wdg_supervisor.sv
module sim_wdg_supervisor;
  import wdg_pkg::*;

  localparam int PW = 16;
  localparam int P  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          kick, sel, dis, ack;
  logic [2:0]    sys;
  logic [PW-1:0] period;
  logic          irq, req;
  logic [2:0]    cause;
  logic [1:0]    mode;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  wdg_supervisor #(.PERIOD_W(PW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_i      (kick),
    .sys_mode_i  (sys),
    .sel_i       (sel),
    .dis_pin_i   (dis),
    .irq_ack_i   (ack),
    .period_i    (period),
    .irq_pend_o  (irq),
    .rst_req_o   (req),
    .rst_cause_o (cause),
    .wd_mode_o   (mode)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick_pulse();
    kick = 1'b1; tick(1); kick = 1'b0;
  endtask

  task automatic settle();
    kick = 1'b0; ack = 1'b0; sys = SYS_SLEEP; tick(3);
  endtask

  task automatic enter(input logic [2:0] s, input logic b);
    settle();
    sel = b; tick(1);
    sys = s; tick(1);
  endtask

  task automatic t_reset();
    check("R12", "irq after reset", int'(irq), 0);
    check("R12", "req after reset", int'(req), 0);
    check("R12", "cause after reset", int'(cause), 0);
    check("R12", "mode after reset", int'(mode), 0);
  endtask

  task automatic t_decode();
    enter(SYS_NORMAL, 1'b0);
    check("R1", "normal sel0 window", int'(mode), 1);
    enter(SYS_NORMAL, 1'b1);
    check("R1", "normal sel1 timeout", int'(mode), 2);
    enter(SYS_STANDBY, 1'b0);
    check("R1", "standby sel0 timeout", int'(mode), 2);
    sel = 1'b1; tick(1);
    check("R1", "standby sel1 off", int'(mode), 0);
    check("R9", "sel change in standby no req", int'(req), 0);
    sys = SYS_OVERTEMP; tick(1);
    check("R1", "overtemp off", int'(mode), 0);
    sys = SYS_OFF; tick(1);
    check("R1", "off mode code off", int'(mode), 0);
    sys = 3'd6; tick(1);
    check("R1", "unused code off", int'(mode), 0);
  endtask

  task automatic t_timeout_escalate();
    enter(SYS_NORMAL, 1'b1);
    tick(P - 1);
    check("R3", "no irq before first overflow", int'(irq), 0);
    tick(1);
    check("R3", "irq on first overflow", int'(irq), 1);
    check("R3", "no req on first overflow", int'(req), 0);
    tick(P - 1);
    check("R4", "no req before second overflow", int'(req), 0);
    tick(1);
    check("R4", "req on second overflow", int'(req), 1);
    check("R4", "escalate cause", int'(cause), 3);
    check("R11", "irq cleared by req", int'(irq), 0);
    tick(1);
    check("R11", "req is one pulse", int'(req), 0);
    check("R11", "cause idle after pulse", int'(cause), 0);
  endtask

  task automatic t_timeout_kick_ack();
    enter(SYS_STANDBY, 1'b0);
    tick(2);
    kick_pulse();
    check("R5", "early kick in timeout no req", int'(req), 0);
    tick(P - 1);
    check("R5", "irq delayed by kick", int'(irq), 0);
    tick(1);
    check("R5", "irq after restarted period", int'(irq), 1);
    ack = 1'b1; tick(1); ack = 1'b0;
    check("R6", "ack clears irq", int'(irq), 0);
    tick(P - 2);
    check("R6", "no irq before next overflow", int'(irq), 0);
    tick(1);
    check("R6", "irq again after ack", int'(irq), 1);
    check("R6", "no req after ack", int'(req), 0);
  endtask

  task automatic t_window_overflow();
    enter(SYS_NORMAL, 1'b0);
    tick(P - 1);
    check("R7", "no req before window end", int'(req), 0);
    tick(1);
    check("R7", "req on missed window", int'(req), 1);
    check("R7", "late cause", int'(cause), 1);
    tick(1);
    check("R11", "window req one pulse", int'(req), 0);
  endtask

  task automatic t_window_kicks();
    enter(SYS_NORMAL, 1'b0);
    tick(3);
    kick_pulse();
    check("R8", "kick at count half-1 req", int'(req), 1);
    check("R8", "early cause", int'(cause), 2);
    enter(SYS_NORMAL, 1'b0);
    tick(4);
    kick_pulse();
    check("R8", "kick at count half no req", int'(req), 0);
    tick(P - 1);
    check("R8", "restarted window no req yet", int'(req), 0);
    tick(1);
    check("R7", "req after restarted window", int'(req), 1);
    check("R7", "late cause after restart", int'(cause), 1);
  endtask

  task automatic t_sel_change();
    enter(SYS_NORMAL, 1'b0);
    tick(2);
    sel = 1'b1; tick(1);
    check("R9", "sel change in normal req", int'(req), 1);
    check("R9", "sel change cause", int'(cause), 4);
    check("R1", "timeout after sel change", int'(mode), 2);
  endtask

  task automatic t_pin_and_off();
    settle();
    sel = 1'b0;
    dis = 1'b1; tick(1);
    check("R10", "pin rise in sleep req", int'(req), 1);
    check("R10", "pin cause", int'(cause), 5);
    sys = SYS_NORMAL; tick(1);
    check("R1", "pin high gives off", int'(mode), 0);
    for (int i = 0; i < 3 * P; i++) begin
      kick = (i % 3 == 0);
      tick(1);
    end
    kick = 1'b0;
    check("R2", "off mode no irq", int'(irq), 0);
    check("R2", "off mode no req", int'(req), 0);
    dis = 1'b0; tick(1);
    check("R10", "pin fall req", int'(req), 1);
    check("R10", "pin fall cause", int'(cause), 5);
    check("R1", "window after pin low", int'(mode), 1);
    settle();
    sel = 1'b1;
    sys = SYS_NORMAL;
    dis = 1'b1; tick(1);
    check("R11", "pin beats sel priority", int'(cause), 5);
    dis = 1'b0; tick(1);
  endtask

  initial begin
    rst_n = 1'b0; kick = 1'b0; sel = 1'b0; dis = 1'b0; ack = 1'b0;
    sys = SYS_SLEEP; period = PW'(P);
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_decode();
    t_timeout_escalate();
    t_timeout_kick_ack();
    t_window_overflow();
    t_window_kicks();
    t_sel_change();
    t_pin_and_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule